// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-interface state machine of a small processor whose low address byte and data byte share one set of pins. A requester hands it one transfer at a time: memory read, memory write, I/O read, I/O write or interrupt acknowledge. The sequencer runs it as a bus cycle of at least four clocks. The low address byte goes out with an address strobe in the first clock, and the same lines then carry or receive data. Slow devices stretch a cycle by holding `ready` low. An external master may take the bus with `hold`, and the sequencer releases the bus only between cycles.

The states are `ST_IDLE` (no cycle), `ST_T1` (address phase), `ST_T2`, `ST_T3`, `ST_TW` (wait) and `ST_T4` (end), plus `ST_HOLD` (bus released). The transitions are as follows:
- IDLE goes to HOLD when `hold` is high, and otherwise to T1 when `req_valid` is high.
- T1 goes to T2, and T2 goes to T3.
- T3 and TW go to T4 when `ready` is high, and to TW otherwise.
- T4 goes back to T1 for the first half of a two-cycle acknowledge, and to IDLE otherwise.
- HOLD stays put while `hold` is high. When `hold` drops it goes to T1 if a request is pending, and to IDLE otherwise.

When `mode_single` is high, an acknowledge is one cycle. When it is low, an acknowledge is two back-to-back cycles under `lock`, and the type byte is taken only from the second cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `ale`, `rd_en`, `wr_en`, `ack_en`, `ad_oe`, `io_m`, `dt_r`, `den`, `lock`, `hlda`, `bus_float` and `done` are all 0.
- R2: A request seen in IDLE starts T1 at the next edge. `ale` is high for exactly that one clock. A cycle with no waits runs four clocks, T1 to T4, and `done` is high in its final T4.
- R3: In T1, `ad_oe`=1, `ad_out`=address[7:0] and `addr_hi`=address[19:8], except for an acknowledge. From T2 to T4, `addr_hi` = {0, is_ack, is_io, is_write, address[15:8]}.
- R4: `ready` is sampled at the edge that ends T3 and at the edge that ends each TW. Each low sample adds one TW, so a cycle with n waits has its strobe high for 2+n clocks. All outputs hold their values from one TW to the next.
- R5: The kind codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 interrupt acknowledge. `io_m` is 1 in the cycles of kinds 2, 3 and 4, and 0 for kinds 0 and 1.
- R6: In reads, `rd_en` and `den` are high in T2, T3 and TW, `dt_r`=0, and `ad_oe`=0 after T1. `rdata` takes `ad_in` at the edge where `ready` is sampled high.
- R7: In writes, `wr_en` is high in T2, T3 and TW, `dt_r`=1 from T1 to T4, and `ad_out`=write data with `ad_oe`=1 from T2 to T4.
- R8: With `mode_single`=1, an acknowledge is one cycle. `ack_en` is high in T2, T3 and TW, `ad_oe`=0 throughout, `lock`=0, and `rdata` is the byte on `ad_in`.
- R9: With `mode_single`=0, an acknowledge is two cycles, with the second T1 directly after the first T4. `lock` is high through both cycles, `done` comes only in the second T4, and `rdata` comes from the second cycle.
- R10: `hold` is honoured only in IDLE, and `hlda` rises one clock later. While `hlda` is high, `bus_float`=1 and `ad_oe`, `ale` and all strobes are 0.
- R11: When `hold` and a request are both present in IDLE, `hold` wins. When `hold` drops, `hlda` falls at the next edge, and that same edge starts T1 of the pending request.
- R12: A `hold` raised during the first acknowledge cycle under `lock` gets no `hlda` until after the second cycle's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request pending |
| req_kind | input | 3 | Cycle kind code (see R5) |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write data |
| mode_single | input | 1 | 1: single acknowledge cycle, 0: two locked cycles |
| ready | input | 1 | Device ready; low inserts a wait state |
| hold | input | 1 | External bus request |
| ad_in | input | 8 | Value sensed on the shared address/data lines |
| addr_hi | output | 12 | Upper address, then status and middle address |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | 1 for I/O and acknowledge, 0 for memory |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| ack_en | output | 1 | Interrupt acknowledge strobe |
| dt_r | output | 1 | Data buffer direction, 1 = transmit |
| den | output | 1 | Data buffer enable |
| lock | output | 1 | Bus locked across a two-cycle acknowledge |
| hlda | output | 1 | Hold granted |
| bus_float | output | 1 | Address, data, control and status float |
| rdata | output | 8 | Last read or acknowledge byte |
| done | output | 1 | Final T4 of the request |

## Verification
Two functions can meet in one cycle. The first is a bus request against a new transfer or a locked acknowledge. The bench raises `hold` in the same idle clock as `req_valid`, and judges that `hlda` comes first and that T1 starts on the exact edge where `hlda` falls. It also raises `hold` during the first half of a two-cycle acknowledge, and judges that no grant appears until two clocks after the second `done`. The second meeting is a wait-state sample against the end of the first acknowledge cycle. The table applies waits to two-cycle acknowledges and checks that both halves stretch, with the total clock count proving there is no idle gap between them.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

    localparam logic [2:0] KIND_MEM_RD = 3'd0;
    localparam logic [2:0] KIND_MEM_WR = 3'd1;
    localparam logic [2:0] KIND_IO_RD  = 3'd2;
    localparam logic [2:0] KIND_IO_WR  = 3'd3;
    localparam logic [2:0] KIND_ACK    = 3'd4;

    typedef struct packed {
        logic is_io;
        logic is_wr;
        logic is_ack;
        logic single;
    } cyc_attr_t;

    function automatic cyc_attr_t decode_kind(logic [2:0] kind, logic single);
        cyc_attr_t a;
        a.is_ack = (kind == KIND_ACK);
        a.is_io  = (kind == KIND_IO_RD) || (kind == KIND_IO_WR);
        a.is_wr  = (kind == KIND_MEM_WR) || (kind == KIND_IO_WR);
        a.single = single;
        return a;
    endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mode_single,
    input  logic              ready,
    input  logic              hold,
    output bus_state_e        state,
    output cyc_attr_t         attr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              final_cyc
);

    bus_state_e st_q, st_d;
    cyc_attr_t  attr_q;
    logic       second_q;
    logic       accept;
    logic       repeat_ack;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (hold)           st_d = ST_HOLD;
                else if (req_valid) st_d = ST_T1;
            end
            ST_T1: st_d = ST_T2;
            ST_T2: st_d = ST_T3;
            ST_T3: st_d = ready ? ST_T4 : ST_TW;
            ST_TW: st_d = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                if (attr_q.is_ack && !attr_q.single && !second_q) st_d = ST_T1;
                else                                              st_d = ST_IDLE;
            end
            ST_HOLD: begin
                if (!hold) st_d = req_valid ? ST_T1 : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign accept     = (st_d == ST_T1) && ((st_q == ST_IDLE) || (st_q == ST_HOLD));
    assign repeat_ack = (st_q == ST_T4) && (st_d == ST_T1);

    // State and request registers
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            attr_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            second_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                attr_q   <= decode_kind(req_kind, mode_single);
                addr_q   <= req_addr;
                wdata_q  <= req_wdata;
                second_q <= 1'b0;
            end else if (repeat_ack) begin
                second_q <= 1'b1;
            end
        end
    end

    assign state     = st_q;
    assign attr      = attr_q;
    assign final_cyc = !attr_q.is_ack || attr_q.single || second_q;

    // The bus is only ever released from the idle boundary
    AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && $past(st_q) != ST_HOLD) |-> $past(st_q) == ST_IDLE); // R10

    // A wait state is entered only from T3 or another wait state
    AST_WAIT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TW) |-> ($past(st_q) == ST_T3 || $past(st_q) == ST_TW)); // R4

endmodule

// File: rtl/bcs_outdec.sv
module bcs_outdec
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bus_state_e               state,
    input  cyc_attr_t                attr,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic                     final_cyc,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     io_m,
    output logic                     rd_en,
    output logic                     wr_en,
    output logic                     ack_en,
    output logic                     dt_r,
    output logic                     den,
    output logic                     lock,
    output logic                     hlda,
    output logic                     bus_float,
    output logic                     done
);

    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int MID_W = HI_W - 4;

    logic in_cyc;
    logic strobe_ph;
    logic [3:0] status;

    always_comb begin
        in_cyc    = (state == ST_T1) || (state == ST_T2) || (state == ST_T3) ||
                    (state == ST_TW) || (state == ST_T4);
        strobe_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
        status    = {1'b0, attr.is_ack, attr.is_io, attr.is_wr};

        ale       = (state == ST_T1);
        hlda      = (state == ST_HOLD);
        bus_float = (state == ST_HOLD);

        if (state == ST_T1) begin
            addr_hi = addr_q[ADDR_W-1:DATA_W];
            ad_out  = addr_q[DATA_W-1:0];
        end else if (in_cyc) begin
            addr_hi = {status, addr_q[DATA_W+MID_W-1:DATA_W]};
            ad_out  = attr.is_wr ? wdata_q : '0;
        end else begin
            addr_hi = '0;
            ad_out  = '0;
        end

        ad_oe  = !attr.is_ack && ((state == ST_T1) || (attr.is_wr && in_cyc));
        io_m   = in_cyc && (attr.is_io || attr.is_ack);
        rd_en  = strobe_ph && !attr.is_wr && !attr.is_ack;
        wr_en  = strobe_ph && attr.is_wr;
        ack_en = strobe_ph && attr.is_ack;
        dt_r   = in_cyc && attr.is_wr;
        den    = strobe_ph;
        lock   = in_cyc && attr.is_ack && !attr.single;
        done   = (state == ST_T4) && final_cyc;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_en, wr_en, ack_en})); // R5

    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (rd_en || ack_en) |-> !ad_oe); // R6

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ale && !rd_en && !wr_en && !ack_en && bus_float)); // R10

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_en || wr_en || ack_en)); // R2

endmodule

// File: rtl/bcs_rdcap.sv
module bcs_rdcap
    import bcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  cyc_attr_t         attr,
    input  logic              final_cyc,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);

    logic take;

    assign take = ((state == ST_T3) || (state == ST_TW)) && ready &&
                  !attr.is_wr && final_cyc;

    always_ff @(posedge clk) begin
        if (rst)       rdata <= '0;
        else if (take) rdata <= ad_in;
    end

    // Captured byte stays put unless a final read phase completes
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TW && $past(state) == ST_TW) |-> $stable(rdata)); // R6

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     mode_single,
    input  logic                     ready,
    input  logic                     hold,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     io_m,
    output logic                     rd_en,
    output logic                     wr_en,
    output logic                     ack_en,
    output logic                     dt_r,
    output logic                     den,
    output logic                     lock,
    output logic                     hlda,
    output logic                     bus_float,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    bus_state_e        state;
    cyc_attr_t         attr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              final_cyc;

    bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .mode_single (mode_single),
        .ready       (ready),
        .hold        (hold),
        .state       (state),
        .attr        (attr),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .final_cyc   (final_cyc)
    );

    bcs_outdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_outdec (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .attr      (attr),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .final_cyc (final_cyc),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .io_m      (io_m),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .ack_en    (ack_en),
        .dt_r      (dt_r),
        .den       (den),
        .lock      (lock),
        .hlda      (hlda),
        .bus_float (bus_float),
        .done      (done)
    );

    bcs_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .attr      (attr),
        .final_cyc (final_cyc),
        .ready     (ready),
        .ad_in     (ad_in),
        .rdata     (rdata)
    );

    // Every bus output is frozen from one wait state to the next
    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TW && $past(state) == ST_TW) |->
        $stable({addr_hi, ad_out, ad_oe, rd_en, wr_en, ack_en, io_m, dt_r, den, lock})); // R4

    // A locked acknowledge keeps the bus away from the external master
    AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        lock |=> !hlda); // R12

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [19:0] req_addr;
    logic [7:0]  req_wdata;
    logic        mode_single;
    logic        ready;
    logic        hold;
    logic [7:0]  ad_in;
    logic [11:0] addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe, ale, io_m, rd_en, wr_en, ack_en, dt_r, den, lock, hlda, bus_float, done;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .mode_single(mode_single),
        .ready(ready), .hold(hold), .ad_in(ad_in), .addr_hi(addr_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .io_m(io_m), .rd_en(rd_en),
        .wr_en(wr_en), .ack_en(ack_en), .dt_r(dt_r), .den(den), .lock(lock),
        .hlda(hlda), .bus_float(bus_float), .rdata(rdata), .done(done)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [7:0]  wd;
        logic        single;
        logic [3:0]  waits;
        logic [7:0]  tbyte;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 20'hA1234, 8'h00, 1'b1, 4'd0, 8'h3C},
        '{3'd1, 20'h5BEEF, 8'hC7, 1'b1, 4'd0, 8'h00},
        '{3'd2, 20'h0F0A5, 8'h00, 1'b1, 4'd2, 8'h96},
        '{3'd3, 20'hE7781, 8'h1E, 1'b1, 4'd3, 8'h00},
        '{3'd0, 20'h3C3C3, 8'h00, 1'b0, 4'd5, 8'hA9},
        '{3'd4, 20'h00000, 8'h00, 1'b1, 4'd0, 8'h21},
        '{3'd4, 20'h00000, 8'h00, 1'b0, 4'd0, 8'h47},
        '{3'd4, 20'h00000, 8'h00, 1'b0, 4'd2, 8'h88},
        '{3'd1, 20'hFFFFF, 8'hFF, 1'b0, 4'd1, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one request and checks it at every falling edge
    task automatic run_req(input vec_t v, input bit hold_mid);
        bit is_ack = (v.kind == 3'd4);
        bit is_io  = (v.kind == 3'd2) || (v.kind == 3'd3);
        bit is_wr  = (v.kind == 3'd1) || (v.kind == 3'd3);
        int ncyc   = (is_ack && !v.single) ? 2 : 1;
        int alec = 0, strobes = 0, c = 0, span = 0, lockcnt = 0;
        bit got_done = 1'b0;
        bit bad_hlda = 1'b0;
        req_kind = v.kind; req_addr = v.addr; req_wdata = v.wd;
        mode_single = v.single; req_valid = 1'b1;
        for (int i = 0; i < 120 && !got_done; i++) begin
            @(negedge clk);
            if (alec > 0 || ale) span++;
            if (hlda) bad_hlda = 1'b1;
            if (lock) lockcnt++;
            if (ale) begin
                alec++; c = 0; req_valid = 1'b0;
                if (hold_mid && alec == 1) hold = 1'b1;
                chk(ad_oe == !is_ack, "R3 T1 drive", ad_oe, !is_ack);
                if (!is_ack) chk(ad_out == v.addr[7:0], "R3 low address", ad_out, v.addr[7:0]);
                chk(addr_hi == v.addr[19:8], "R3 high address", addr_hi, v.addr[19:8]);
                chk(dt_r == is_wr, "R7 direction T1", dt_r, is_wr);
            end
            if (rd_en || wr_en || ack_en) begin
                c++; strobes++;
                chk(addr_hi == {1'b0, is_ack, is_io, is_wr, v.addr[15:8]}, "R3 status", addr_hi,
                    {1'b0, is_ack, is_io, is_wr, v.addr[15:8]});
                chk(io_m == (is_io || is_ack), "R5 io_m", io_m, is_io || is_ack);
                chk({rd_en, wr_en, ack_en} == {!is_wr && !is_ack, is_wr, is_ack}, "R5 strobe kind",
                    {rd_en, wr_en, ack_en}, {!is_wr && !is_ack, is_wr, is_ack});
                chk(den == 1'b1, "R6 buffer enable", den, 1);
                if (is_wr) chk(ad_oe && ad_out == v.wd, "R7 write data", ad_out, v.wd);
                else       chk(!ad_oe && !dt_r, "R6 read floats", {ad_oe, dt_r}, 0);
                ready = (c >= 2 + v.waits);
            end else begin
                ready = 1'b1;
            end
            ad_in = (is_ack && !v.single && alec < 2) ? 8'h5A : v.tbyte;
            if (done) begin
                got_done = 1'b1;
                chk(alec == ncyc, is_ack ? "R9 acknowledge count" : "R2 one address phase", alec, ncyc);
                chk(span == ncyc * (4 + v.waits), "R4 cycle length", span, ncyc * (4 + v.waits));
                chk(strobes == ncyc * (2 + v.waits), "R4 strobe length", strobes, ncyc * (2 + v.waits));
                chk(lockcnt == ((is_ack && !v.single) ? span : 0), is_ack && !v.single ?
                    "R9 lock span" : "R8 no lock", lockcnt, span);
                if (!is_wr) chk(rdata == v.tbyte, is_ack ? "R8 R9 type byte" : "R6 read data", rdata, v.tbyte);
                chk(!bad_hlda, hold_mid && is_ack ? "R12 locked no grant" : "R10 no grant mid cycle", bad_hlda, 0);
            end
        end
        chk(got_done, "R2 done seen", got_done, 1);
        ready = 1'b1;
        if (hold_mid) begin
            @(negedge clk); chk(!hlda, "R10 grant waits for idle", hlda, 0);
            @(negedge clk); chk(hlda && bus_float, "R10 grant after cycle", {hlda, bus_float}, 2'b11);
            hold = 1'b0;
            @(negedge clk); chk(!hlda, "R11 grant release", hlda, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_wdata = '0;
        mode_single = 1'b1; ready = 1'b1; hold = 1'b0; ad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({ale, rd_en, wr_en, ack_en, ad_oe, io_m, dt_r, den, lock, hlda, bus_float, done} == '0,
            "R1 reset outputs", {ale, rd_en, wr_en, ack_en, ad_oe, io_m, dt_r, den, lock, hlda, bus_float, done}, 0);

        for (int i = 0; i < NV; i++) run_req(VECS[i], 1'b0);

        // R10 hold in idle
        hold = 1'b1;
        @(negedge clk);
        chk(hlda && bus_float && !ad_oe && !ale, "R10 idle grant", {hlda, bus_float, ad_oe, ale}, 4'b1100);
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda && !bus_float, "R10 release", {hlda, bus_float}, 0);

        // R11 hold and request in the same idle clock
        hold = 1'b1; req_valid = 1'b1; req_kind = 3'd0; req_addr = 20'h12345; mode_single = 1'b1;
        @(negedge clk);
        chk(hlda && !ale, "R11 hold wins", {hlda, ale}, 2'b10);
        repeat (3) @(negedge clk);
        chk(hlda && !ale && !rd_en, "R11 request waits", {hlda, ale, rd_en}, 3'b100);
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda && ale && addr_hi == 12'h123, "R11 T1 on release", {hlda, ale, addr_hi}, {2'b01, 12'h123});
        req_valid = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        chk(done, "R11 deferred cycle completes", done, 1);
        @(negedge clk);

        // R10 hold during a waited read; R12 hold during a locked acknowledge
        run_req('{3'd2, 20'h0ABCD, 8'h00, 1'b1, 4'd2, 8'h6D}, 1'b1);
        run_req('{3'd4, 20'h00000, 8'h00, 1'b0, 4'd1, 8'h9E}, 1'b1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule